// File: doc/BRIEF.md
# Exception Condition Detector and Vector Generator

This block sits beside the completion stage of a processor core and turns status signals into a single exception request. Each cycle it looks at the class of the instruction about to complete, the low bits of its data address, the page attributes of that access, a handful of machine-state and control bits, and several external request lines. When one or more exception conditions hold, it picks the one with the highest priority, raises a one-cycle request strobe and presents the matching 20-bit vector offset. It then waits for an acknowledge before it raises another request.

Instruction-caused conditions are covered: misaligned word-sized accesses, multiple/string accesses in little-endian mode, cache block zeroing of memory that cannot be cached, the system call, single-step and branch tracing, and an instruction address breakpoint. Asynchronous conditions are covered too: a system management request, a die temperature above a programmed threshold, the sign bit of the decrementer turning on, and a performance counter reaching its limit. A decrementer transition that arrives while external interrupts are masked is remembered until it can be delivered. Saving machine state, fetching the handler and the decrementer counter itself belong to other blocks.

Top module: `exc_vector_gen`

## Requirements
- R1: With `inst_valid` high and `data_ea_lo` not 0, the classes floating-point memory (1), load multiple (2), store multiple (3), load reserved (4), store conditional (5), external in (6) and external out (7) raise vector 0x00600; with `data_ea_lo` equal to 0 they raise nothing.
- R2: With `inst_valid` high and `le_mode` high, classes load multiple (2), store multiple (3) and string (8) raise vector 0x00600 at any address; string with `le_mode` low and an aligned address raises nothing.
- R3: With `inst_valid` high, the block-zero class (9) raises vector 0x00600 when `pg_wt` or `pg_ci` is high or `dcache_en` is low, and nothing otherwise.
- R4: With `inst_valid` high, the system call class (10) raises vector 0x00C00.
- R5: With `inst_valid` high, vector 0x00D00 is raised when `msr_se` is high, or when the class is branch (11) and `msr_be` is high; the synchronize class (12) never raises it.
- R6: With `inst_valid` high, vector 0x01300 is raised when `bp_be` is high, `bp_te` equals `msr_ir` and `bp_word` equals `next_pc_word`.
- R7: Vector 0x01400 is raised while `smi_req` and `msr_ee` are both high.
- R8: Vector 0x01700 is raised while `therm_en` and `msr_ee` are high and `junct_temp` is greater than `therm_thr1` or `therm_thr2`.
- R9: A 0-to-1 change of `dec_msb` sets a pending flag; vector 0x00900 is raised only while `msr_ee` is high, the pending flag holds while `msr_ee` is low, and a `dec_msb` that stays high raises it once.
- R10: Vector 0x00F00 is raised while `pmc_hit` and `pm_int_en` are both high, regardless of `msr_ee`.
- R11: When several conditions hold, priority from high to low is 0x00600, 0x00C00, 0x00D00, 0x01300, 0x01400, 0x01700, 0x00900, 0x00F00.
- R12: `exc_req` is high for exactly one cycle per request, no new request is raised until `exc_ack` has been sampled high, `exc_vec` holds its value between requests and is never a reserved offset.
- R13: After reset `exc_req` is 0 and `exc_vec` is 0; a request becomes visible one clock edge after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_valid | input | 1 | An instruction is at completion this cycle |
| inst_class | input | 4 | Class code of that instruction (see requirements) |
| data_ea_lo | input | 2 | Byte offset bits of its data effective address |
| pg_wt | input | 1 | Target page requires write-through |
| pg_ci | input | 1 | Target page is caching-inhibited |
| dcache_en | input | 1 | Data cache is enabled |
| le_mode | input | 1 | Little-endian mode is active |
| msr_ee | input | 1 | External interrupt enable |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| msr_ir | input | 1 | Instruction relocation enable |
| next_pc_word | input | 30 | Word address of the next instruction to complete |
| bp_word | input | 30 | Breakpoint word address |
| bp_te | input | 1 | Breakpoint translation match value |
| bp_be | input | 1 | Breakpoint enable |
| dec_msb | input | 1 | Most significant bit of the decrementer |
| smi_req | input | 1 | System management request line |
| therm_en | input | 1 | Thermal monitoring enabled |
| junct_temp | input | 8 | Junction temperature reading |
| therm_thr1 | input | 8 | First temperature threshold |
| therm_thr2 | input | 8 | Second temperature threshold |
| pmc_hit | input | 1 | A performance counter reached its limit |
| pm_int_en | input | 1 | Performance monitor interrupt enable |
| exc_ack | input | 1 | Acknowledge of the outstanding request |
| exc_req | output | 1 | One-cycle exception request strobe |
| exc_vec | output | 20 | Vector offset of the request |

## Verification
On every cycle the assertions check the handshake (a strobe never lasts two cycles and never appears while an acknowledge is outstanding), that every issued offset is a legal vector, that the masked asynchronous vectors only appear when the interrupt enable was set, that a masked decrementer event stays pending, that instruction-caused sources beat asynchronous ones, and that the synchronize class never traces. Which vector each instruction class, address offset and page attribute combination selects, the breakpoint compare, the exact order among sources of the same kind and the one-shot behaviour of a decrementer bit that stays high can only be shown by the bench's scenarios with their computed expectations.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int VEC_W   = 20;
  localparam int NUM_SRC = 8;

  // Instruction class codes seen at completion
  typedef enum logic [3:0] {
    CL_ALU         = 4'd0,
    CL_FLT_MEM     = 4'd1,
    CL_LOAD_MULTI  = 4'd2,
    CL_STORE_MULTI = 4'd3,
    CL_LOAD_RSV    = 4'd4,
    CL_STORE_COND  = 4'd5,
    CL_EXT_IN      = 4'd6,
    CL_EXT_OUT     = 4'd7,
    CL_STRING      = 4'd8,
    CL_BLK_ZERO    = 4'd9,
    CL_SYSCALL     = 4'd10,
    CL_BRANCH      = 4'd11,
    CL_SYNC        = 4'd12
  } inst_cls_e;

  // Source index doubles as priority: index 0 wins
  localparam int SRC_ALIGN = 0;
  localparam int SRC_SC    = 1;
  localparam int SRC_TRACE = 2;
  localparam int SRC_BKPT  = 3;
  localparam int SRC_SMI   = 4;
  localparam int SRC_THERM = 5;
  localparam int SRC_DEC   = 6;
  localparam int SRC_PMON  = 7;

  localparam logic [VEC_W-1:0] V_ALIGN = 20'h00600;
  localparam logic [VEC_W-1:0] V_DEC   = 20'h00900;
  localparam logic [VEC_W-1:0] V_SC    = 20'h00C00;
  localparam logic [VEC_W-1:0] V_TRACE = 20'h00D00;
  localparam logic [VEC_W-1:0] V_PMON  = 20'h00F00;
  localparam logic [VEC_W-1:0] V_BKPT  = 20'h01300;
  localparam logic [VEC_W-1:0] V_SMI   = 20'h01400;
  localparam logic [VEC_W-1:0] V_THERM = 20'h01700;

  function automatic logic [VEC_W-1:0] src_vec(input int idx);
    case (idx)
      SRC_ALIGN: src_vec = V_ALIGN;
      SRC_SC:    src_vec = V_SC;
      SRC_TRACE: src_vec = V_TRACE;
      SRC_BKPT:  src_vec = V_BKPT;
      SRC_SMI:   src_vec = V_SMI;
      SRC_THERM: src_vec = V_THERM;
      SRC_DEC:   src_vec = V_DEC;
      default:   src_vec = V_PMON;
    endcase
  endfunction

  // Classes that demand a word-aligned operand
  function automatic logic needs_word_align(input logic [3:0] cls);
    needs_word_align = (cls >= 4'(CL_FLT_MEM)) && (cls <= 4'(CL_EXT_OUT));
  endfunction

  // Multiple or string transfers
  function automatic logic is_multi_xfer(input logic [3:0] cls);
    is_multi_xfer = (cls == 4'(CL_LOAD_MULTI)) || (cls == 4'(CL_STORE_MULTI)) ||
                    (cls == 4'(CL_STRING));
  endfunction

  // Lowest set index wins; result is one-hot or zero
  function automatic logic [NUM_SRC-1:0] pick_first(input logic [NUM_SRC-1:0] hits);
    pick_first = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hits[i]) pick_first = NUM_SRC'(1) << i;
    end
  endfunction

  function automatic logic [VEC_W-1:0] onehot_vec(input logic [NUM_SRC-1:0] sel);
    onehot_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel[i]) onehot_vec = onehot_vec | src_vec(i);
    end
  endfunction

  function automatic logic legal_vec(input logic [VEC_W-1:0] v);
    legal_vec = (v == V_ALIGN) || (v == V_DEC) || (v == V_SC) || (v == V_TRACE) ||
                (v == V_PMON) || (v == V_BKPT) || (v == V_SMI) || (v == V_THERM);
  endfunction

endpackage

// File: rtl/exc_sync_detect.sv
module exc_sync_detect
  import exc_pkg::*;
#(
  parameter int PC_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inst_valid,
  input  logic [3:0]      inst_class,
  input  logic [1:0]      data_ea_lo,
  input  logic            pg_wt,
  input  logic            pg_ci,
  input  logic            dcache_en,
  input  logic            le_mode,
  input  logic            msr_se,
  input  logic            msr_be,
  input  logic            msr_ir,
  input  logic [PC_W-1:0] next_pc_word,
  input  logic [PC_W-1:0] bp_word,
  input  logic            bp_te,
  input  logic            bp_be,
  output logic [3:0]      sync_hits
);

  logic misalign_hit;
  logic endian_hit;
  logic blkzero_hit;
  logic align_hit;
  logic sc_hit;
  logic trace_hit;
  logic bkpt_hit;

  assign misalign_hit = needs_word_align(inst_class) && (data_ea_lo != 2'b00);
  assign endian_hit   = is_multi_xfer(inst_class) && le_mode;
  assign blkzero_hit  = (inst_class == 4'(CL_BLK_ZERO)) && (pg_wt || pg_ci || !dcache_en);
  assign align_hit    = inst_valid && (misalign_hit || endian_hit || blkzero_hit);

  assign sc_hit = inst_valid && (inst_class == 4'(CL_SYSCALL));

  assign trace_hit = inst_valid && (inst_class != 4'(CL_SYNC)) &&
                     (msr_se || (msr_be && (inst_class == 4'(CL_BRANCH))));

  assign bkpt_hit = inst_valid && bp_be && (bp_te == msr_ir) && (bp_word == next_pc_word);

  assign sync_hits = {bkpt_hit, trace_hit, sc_hit, align_hit};

  // R5: the synchronize class never produces a trace condition
  p_sync_no_trace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_class == 4'(CL_SYNC)) |-> !sync_hits[SRC_TRACE]);

  // R6: breakpoint needs its enable
  p_bkpt_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hits[SRC_BKPT] |-> bp_be);

  // Nothing instruction-caused without a completing instruction
  p_sync_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |-> (sync_hits == 4'b0000));

endmodule

// File: rtl/exc_async_detect.sv
module exc_async_detect
  import exc_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msr_ee,
  input  logic              dec_msb,
  input  logic              smi_req,
  input  logic              therm_en,
  input  logic [TEMP_W-1:0] junct_temp,
  input  logic [TEMP_W-1:0] therm_thr1,
  input  logic [TEMP_W-1:0] therm_thr2,
  input  logic              pmc_hit,
  input  logic              pm_int_en,
  input  logic              dec_taken,
  output logic [3:0]        async_hits,
  output logic              dec_pending
);

  logic dec_msb_q;
  logic dec_edge;
  logic dec_live;
  logic smi_hit;
  logic therm_hit;
  logic dec_hit;
  logic pmon_hit;
  logic over_thr;

  assign dec_edge = dec_msb && !dec_msb_q;
  assign dec_live = dec_pending || dec_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_msb_q   <= 1'b0;
      dec_pending <= 1'b0;
    end else begin
      dec_msb_q   <= dec_msb;
      dec_pending <= dec_live && !dec_taken;
    end
  end

  assign over_thr  = (junct_temp > therm_thr1) || (junct_temp > therm_thr2);
  assign smi_hit   = smi_req && msr_ee;
  assign therm_hit = therm_en && over_thr && msr_ee;
  assign dec_hit   = dec_live && msr_ee;
  assign pmon_hit  = pmc_hit && pm_int_en;

  assign async_hits = {pmon_hit, dec_hit, therm_hit, smi_hit};

  // R9: a masked decrementer event is held
  p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pending && !msr_ee) |=> dec_pending);

  // R9: delivery only with interrupts enabled
  p_dec_take_ee_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_taken |-> msr_ee);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       sync_hits,
  input  logic [3:0]       async_hits,
  input  logic             exc_ack,
  output logic             dec_taken,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec
);

  logic               busy;
  logic [NUM_SRC-1:0] all_hits;
  logic [NUM_SRC-1:0] grant;
  logic               any_hit;

  assign all_hits  = {async_hits, sync_hits};
  assign grant     = busy ? '0 : pick_first(all_hits);
  assign any_hit   = |grant;
  assign dec_taken = grant[SRC_DEC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      exc_req <= 1'b0;
      exc_vec <= '0;
    end else if (busy) begin
      exc_req <= 1'b0;
      if (exc_ack) busy <= 1'b0;
    end else if (any_hit) begin
      exc_req <= 1'b1;
      exc_vec <= onehot_vec(grant);
      busy    <= 1'b1;
    end else begin
      exc_req <= 1'b0;
    end
  end

  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !exc_req);

  p_wait_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exc_ack) |=> !exc_req);

  p_legal_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> legal_vec(exc_vec));

  p_vec_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> $stable(exc_vec) || $rose(exc_req));

  p_sync_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|sync_hits) && (|async_hits)) |=>
      (exc_req && ((exc_vec == V_ALIGN) || (exc_vec == V_SC) ||
                   (exc_vec == V_TRACE) || (exc_vec == V_BKPT))));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid,
  input  logic [3:0]        inst_class,
  input  logic [1:0]        data_ea_lo,
  input  logic              pg_wt,
  input  logic              pg_ci,
  input  logic              dcache_en,
  input  logic              le_mode,
  input  logic              msr_ee,
  input  logic              msr_se,
  input  logic              msr_be,
  input  logic              msr_ir,
  input  logic [PC_W-1:0]   next_pc_word,
  input  logic [PC_W-1:0]   bp_word,
  input  logic              bp_te,
  input  logic              bp_be,
  input  logic              dec_msb,
  input  logic              smi_req,
  input  logic              therm_en,
  input  logic [TEMP_W-1:0] junct_temp,
  input  logic [TEMP_W-1:0] therm_thr1,
  input  logic [TEMP_W-1:0] therm_thr2,
  input  logic              pmc_hit,
  input  logic              pm_int_en,
  input  logic              exc_ack,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec
);

  logic [3:0] sync_hits;
  logic [3:0] async_hits;
  logic       dec_taken;
  logic       dec_pending;

  exc_sync_detect #(.PC_W(PC_W)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .inst_valid   (inst_valid),
    .inst_class   (inst_class),
    .data_ea_lo   (data_ea_lo),
    .pg_wt        (pg_wt),
    .pg_ci        (pg_ci),
    .dcache_en    (dcache_en),
    .le_mode      (le_mode),
    .msr_se       (msr_se),
    .msr_be       (msr_be),
    .msr_ir       (msr_ir),
    .next_pc_word (next_pc_word),
    .bp_word      (bp_word),
    .bp_te        (bp_te),
    .bp_be        (bp_be),
    .sync_hits    (sync_hits)
  );

  exc_async_detect #(.TEMP_W(TEMP_W)) u_async (
    .clk         (clk),
    .rst_n       (rst_n),
    .msr_ee      (msr_ee),
    .dec_msb     (dec_msb),
    .smi_req     (smi_req),
    .therm_en    (therm_en),
    .junct_temp  (junct_temp),
    .therm_thr1  (therm_thr1),
    .therm_thr2  (therm_thr2),
    .pmc_hit     (pmc_hit),
    .pm_int_en   (pm_int_en),
    .dec_taken   (dec_taken),
    .async_hits  (async_hits),
    .dec_pending (dec_pending)
  );

  exc_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_hits  (sync_hits),
    .async_hits (async_hits),
    .exc_ack    (exc_ack),
    .dec_taken  (dec_taken),
    .exc_req    (exc_req),
    .exc_vec    (exc_vec)
  );

  // R7, R8, R9: masked vectors only follow an enabled cycle
  p_smi_ee_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && (exc_vec == V_SMI)) |-> $past(msr_ee));

  p_therm_ee_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && (exc_vec == V_THERM)) |-> $past(msr_ee));

  p_dec_ee_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && (exc_vec == V_DEC)) |-> $past(msr_ee));

  // R5: trace vector never follows a synchronize instruction
  p_no_sync_trace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && (exc_vec == V_TRACE)) |-> ($past(inst_class) != 4'(CL_SYNC)));

  p_pend_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pending && msr_ee && !dec_taken) |=> dec_pending);

endmodule

// File: tb/tb_exc_vector_gen.sv
module tb_exc_vector_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 0;
  logic [3:0]  inst_class = 0;
  logic [1:0]  data_ea_lo = 0;
  logic        pg_wt = 0, pg_ci = 0, dcache_en = 1, le_mode = 0;
  logic        msr_ee = 0, msr_se = 0, msr_be = 0, msr_ir = 0;
  logic [29:0] next_pc_word = 0, bp_word = 0;
  logic        bp_te = 0, bp_be = 0, dec_msb = 0, smi_req = 0, therm_en = 0;
  logic [7:0]  junct_temp = 8'd50, therm_thr1 = 8'd100, therm_thr2 = 8'd80;
  logic        pmc_hit = 0, pm_int_en = 0, exc_ack = 0;
  logic        exc_req;
  logic [19:0] exc_vec;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_vector_gen dut (.*);

  typedef struct packed {
    logic [3:0]  cls;
    logic [1:0]  lo;
    logic        le, wt, ci, dce, se, be, ee, smi, hot, pmc, pmen;
    logic        xreq;
    logic [19:0] xvec;
    logic [7:0]  rq;
  } row_t;

  localparam int NROWS = 24;
  //                cls  lo le wt ci dce se be ee smi hot pmc pmen xreq xvec     rq
  localparam row_t ROWS [NROWS] = '{
    '{4'd1,  2'd2, 0,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd1},  // R1 fp misaligned
    '{4'd1,  2'd0, 0,0,0,1, 0,0,0, 0,0,0,0, 0, 20'h00000, 8'd1},  // R1 fp aligned
    '{4'd4,  2'd1, 0,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd1},  // R1 load reserved
    '{4'd7,  2'd3, 0,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd1},  // R1 external out
    '{4'd8,  2'd0, 1,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd2},  // R2 string LE
    '{4'd8,  2'd0, 0,0,0,1, 0,0,0, 0,0,0,0, 0, 20'h00000, 8'd2},  // R2 string BE
    '{4'd2,  2'd0, 1,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd2},  // R2 load multi LE
    '{4'd9,  2'd0, 0,0,1,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd3},  // R3 inhibited
    '{4'd9,  2'd0, 0,1,0,1, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd3},  // R3 write-through
    '{4'd9,  2'd0, 0,0,0,0, 0,0,0, 0,0,0,0, 1, 20'h00600, 8'd3},  // R3 cache off
    '{4'd9,  2'd0, 0,0,0,1, 0,0,0, 0,0,0,0, 0, 20'h00000, 8'd3},  // R3 cacheable
    '{4'd10, 2'd0, 0,0,0,1, 0,0,0, 0,0,0,0, 1, 20'h00C00, 8'd4},  // R4 syscall
    '{4'd0,  2'd0, 0,0,0,1, 1,0,0, 0,0,0,0, 1, 20'h00D00, 8'd5},  // R5 single step
    '{4'd12, 2'd0, 0,0,0,1, 1,1,0, 0,0,0,0, 0, 20'h00000, 8'd5},  // R5 sync no trace
    '{4'd11, 2'd0, 0,0,0,1, 0,1,0, 0,0,0,0, 1, 20'h00D00, 8'd5},  // R5 branch trace
    '{4'd0,  2'd0, 0,0,0,1, 0,1,0, 0,0,0,0, 0, 20'h00000, 8'd5},  // R5 non-branch
    '{4'd0,  2'd0, 0,0,0,1, 0,0,1, 1,0,0,0, 1, 20'h01400, 8'd7},  // R7 smi
    '{4'd0,  2'd0, 0,0,0,1, 0,0,0, 1,0,0,0, 0, 20'h00000, 8'd7},  // R7 smi masked
    '{4'd0,  2'd0, 0,0,0,1, 0,0,1, 0,1,0,0, 1, 20'h01700, 8'd8},  // R8 thermal
    '{4'd0,  2'd0, 0,0,0,1, 0,0,0, 0,0,1,1, 1, 20'h00F00, 8'd10}, // R10 pmon, EE off
    '{4'd0,  2'd0, 0,0,0,1, 0,0,1, 0,0,1,0, 0, 20'h00000, 8'd10}, // R10 pmon disabled
    '{4'd10, 2'd0, 0,0,0,1, 0,0,1, 1,1,1,1, 1, 20'h00C00, 8'd11}, // R11 sync beats async
    '{4'd0,  2'd0, 0,0,0,1, 0,0,1, 1,1,1,1, 1, 20'h01400, 8'd11}, // R11 smi first
    '{4'd8,  2'd1, 1,0,0,1, 1,0,1, 0,1,1,1, 1, 20'h00600, 8'd11}  // R11 align beats trace
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic clear_inputs();
    inst_valid = 0; inst_class = 0; data_ea_lo = 0; pg_wt = 0; pg_ci = 0;
    dcache_en = 1; le_mode = 0; msr_ee = 0; msr_se = 0; msr_be = 0;
    smi_req = 0; therm_en = 0; junct_temp = 8'd50; pmc_hit = 0; pm_int_en = 0;
    bp_be = 0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    clear_inputs();
    exc_ack = 1;
    @(negedge clk);
    exc_ack = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 req", 32'(exc_req), 0);
    check("R13 vec", 32'(exc_vec), 0);
    rst_n = 1;
    @(negedge clk);
    check("R13 idle", 32'(exc_req), 0);

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      r = ROWS[i];
      inst_valid = 1; inst_class = r.cls; data_ea_lo = r.lo; le_mode = r.le;
      pg_wt = r.wt; pg_ci = r.ci; dcache_en = r.dce; msr_se = r.se; msr_be = r.be;
      msr_ee = r.ee; smi_req = r.smi; therm_en = r.hot;
      junct_temp = r.hot ? 8'd90 : 8'd50; pmc_hit = r.pmc; pm_int_en = r.pmen;
      @(negedge clk);
      check($sformatf("R%0d row%0d req", r.rq, i), 32'(exc_req), 32'(r.xreq));
      if (r.xreq) begin
        check($sformatf("R%0d row%0d vec", r.rq, i), 32'(exc_vec), 32'(r.xvec));
        do_ack();
      end else begin
        clear_inputs();
        @(negedge clk);
      end
    end

    // R6: breakpoint match, ignoring nothing but the compared fields
    next_pc_word = 30'h1234567; bp_word = 30'h1234567; bp_te = 1; msr_ir = 1;
    bp_be = 1; inst_valid = 1;
    @(negedge clk);
    check("R6 match req", 32'(exc_req), 1);
    check("R6 match vec", 32'(exc_vec), 32'h01300);
    do_ack();
    inst_valid = 1; bp_be = 1; msr_ir = 0;
    @(negedge clk);
    check("R6 te mismatch", 32'(exc_req), 0);
    msr_ir = 1; bp_word = 30'h1234566;
    @(negedge clk);
    check("R6 addr mismatch", 32'(exc_req), 0);
    bp_be = 0; bp_word = 30'h1234567;
    @(negedge clk);
    check("R6 disabled", 32'(exc_req), 0);
    clear_inputs();

    // R9: masked edge pends, then delivers once EE is set
    @(negedge clk);
    dec_msb = 1;
    @(negedge clk);
    check("R9 masked", 32'(exc_req), 0);
    repeat (3) @(negedge clk);
    check("R9 still masked", 32'(exc_req), 0);
    msr_ee = 1;
    @(negedge clk);
    check("R9 pend req", 32'(exc_req), 1);
    check("R9 pend vec", 32'(exc_vec), 32'h00900);
    @(negedge clk);
    exc_ack = 1;
    @(negedge clk);
    exc_ack = 0;
    repeat (3) @(negedge clk);
    check("R9 no repeat", 32'(exc_req), 0);
    dec_msb = 0;
    @(negedge clk);
    dec_msb = 1;
    @(negedge clk);
    check("R9 direct req", 32'(exc_req), 1);
    check("R9 direct vec", 32'(exc_vec), 32'h00900);
    do_ack();
    dec_msb = 0;

    // R12: one-cycle strobe, wait for ack, vector held
    smi_req = 1; msr_ee = 1;
    @(negedge clk);
    check("R12 first", 32'(exc_req), 1);
    @(negedge clk);
    check("R12 one cycle", 32'(exc_req), 0);
    repeat (2) @(negedge clk);
    check("R12 waits", 32'(exc_req), 0);
    check("R12 vec held", 32'(exc_vec), 32'h01400);
    exc_ack = 1;
    @(negedge clk);
    check("R12 ack edge", 32'(exc_req), 0);
    exc_ack = 0;
    @(negedge clk);
    check("R12 re-raise", 32'(exc_req), 1);
    check("R12 re-raise vec", 32'(exc_vec), 32'h01400);
    do_ack();

    // R13: no instruction, no sync source
    msr_se = 1; inst_class = 4'd10;
    @(negedge clk);
    check("R13 invalid inst", 32'(exc_req), 0);
    clear_inputs();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule